// File: doc/BRIEF.md
# Fractional-capable programmable feedback divider

This block sits in the feedback path of a frequency synthesizer and divides a fast input clock down to the phase-comparison rate. It emits a one-cycle pulse at the end of every divided period. The length of each period is a programmed base ratio. In fractional mode a signed offset from an external delta-sigma modulator is added to that base, one new offset per period. An optional divide-by-2 prescaler in front of the counter doubles every ratio, so the total ratios it gives are always even.

The programmed ratio is checked against the legal window for the active mode. In fractional mode the window is narrower by the largest offset allowed at each end. A setting outside the window raises an error flag, and the counter runs with the nearest legal value instead.

A small finite-state machine controls the counter. It has two states:
- `ST_START`: entered on reset. On the first counting tick it loads the clamped base ratio with no offset and takes the transition *arm* into `ST_RUN`.
- `ST_RUN`: counts down one step per tick. When the count reaches zero it fires the pulse and takes the transition *reload*, which stays in `ST_RUN`. The reload uses the base plus the offset sampled at that moment.

The divided pulse can also be routed to a test-observation pin through a select code.

Top module: `fbdiv_top`

## Requirements
- R1: With `frac_en` low, the legal ratio is any integer from MIN_INT (16) to 2^NW−1 (524,287 at NW=19). A value outside that window sets `range_err` in the same cycle, and the counter uses the nearer bound instead.
- R2: With `frac_en` high, the legal window is MIN_INT+4 (20) to 2^NW−5 (524,283 at NW=19). A value outside it sets `range_err`, and the nearer of those two bounds is used instead.
- R3: With `frac_en` high, each period after the first lasts the clamped ratio plus the signed offset `dsm_off`, read as two's complement. With `frac_en` low the offset has no effect.
- R4: An offset above +4 acts as +4, and an offset below −4 acts as −4 (for example 4'b0111 acts as +4 and 4'b1000 acts as −4).
- R5: The offset is sampled only at the period boundary, when the pulse fires. A change of `dsm_off` part-way through a period leaves that period's length unchanged and takes effect from the next period.
- R6: The first period after reset uses the clamped base with no offset. Count the first rising edge with `rst` low as edge 1. The first pulse is then high in the cycle after edge M·(B−1), where B is the clamped base and M is 2 with `presc_en` high and 1 otherwise.
- R7: With `presc_en` low, the pulses are N input cycles apart, where N is the per-period value. With `presc_en` high, they are 2·N cycles apart, so the total ratio is always even.
- R8: `div_pulse` is high for exactly one input-clock cycle per period.
- R9: `test_out` follows `div_pulse` when `tsel` equals 10 (decimal), and is low for any other code.
- R10: A synchronous reset clears the counter and the prescaler phase. While `rst` is high, `div_pulse` and `test_out` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| div_val | input | NW | Programmed base divide ratio |
| frac_en | input | 1 | Fractional mode: add the modulator offset each period |
| dsm_off | input | OW | Signed per-period offset from the modulator |
| presc_en | input | 1 | Enable the fixed divide-by-2 prescaler |
| tsel | input | TSW | Test-observation select code |
| div_pulse | output | 1 | One-cycle pulse at each period end |
| test_out | output | 1 | Divided pulse when `tsel` is 10, else low |
| range_err | output | 1 | Programmed ratio illegal for the current mode |

## Verification
The bench builds the block with NW=6, so the integer ceiling is 63 and the fractional ceiling is 59. With these values the upper clamp and a full maximum-length period take only a few dozen cycles, and the bench can check both ends of both legal windows against measured pulse spacing. The other parameters keep their defaults: a 4-bit offset can reach the codes beyond ±4 that saturation must catch, and the 5-bit select field can reach code 10 as well as a code next to it.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

    typedef enum logic [0:0] {
        ST_START = 1'b0,
        ST_RUN   = 1'b1
    } div_state_t;

endpackage

// File: rtl/fbdiv_limits.sv
module fbdiv_limits #(
    parameter int NW      = 19,
    parameter int OW      = 4,
    parameter int MIN_INT = 16,
    parameter int MARGIN  = 4
) (
    input  logic [NW-1:0] base,
    input  logic          frac_en,
    input  logic [OW-1:0] offset,
    output logic [NW-1:0] base_legal,
    output logic [NW-1:0] period_val,
    output logic          err
);
    localparam int MAXV     = (1 << NW) - 1;
    localparam int FRAC_MIN = MIN_INT + MARGIN;
    localparam int FRAC_MAX = MAXV - MARGIN;

    int lo;
    int hi;
    int base_i;
    int off_i;
    int sum_i;

    always_comb begin
        lo     = frac_en ? FRAC_MIN : MIN_INT;
        hi     = frac_en ? FRAC_MAX : MAXV;
        base_i = int'(base);
        err    = (base_i < lo) || (base_i > hi);
        if (base_i < lo) begin
            base_i = lo;
        end else if (base_i > hi) begin
            base_i = hi;
        end
        base_legal = base_i[NW-1:0];

        off_i = int'($signed(offset));
        if (off_i > MARGIN) begin
            off_i = MARGIN;
        end else if (off_i < -MARGIN) begin
            off_i = -MARGIN;
        end
        if (!frac_en) begin
            off_i = 0;
        end
        sum_i      = base_i + off_i;
        period_val = sum_i[NW-1:0];
    end

    // R1 R2: a legal setting passes through untouched, and the result stays in the window
    always_comb begin
        if (!err) begin
            p_legal_passthru_r1: assert (base_legal == base);
        end
        p_clamp_window_r2: assert (int'(base_legal) >= lo && int'(base_legal) <= hi);
    end

endmodule

// File: rtl/fbdiv_presc.sv
module fbdiv_presc (
    input  logic clk,
    input  logic rst,
    input  logic presc_en,
    output logic tick
);
    logic phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= 1'b1;
        end else if (presc_en) begin
            phase <= ~phase;
        end else begin
            phase <= 1'b1;
        end
    end

    always_comb begin
        tick = presc_en ? phase : 1'b1;
    end

    // R7: with the prescaler on, counting ticks never fall in two consecutive cycles
    p_presc_gap_r7: assert property (@(posedge clk) disable iff (rst)
        (presc_en && tick) |=> (!tick || !presc_en));

endmodule

// File: rtl/fbdiv_count.sv
module fbdiv_count
    import fbdiv_pkg::*;
#(
    parameter int NW      = 19,
    parameter int MIN_INT = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [NW-1:0] first_val,
    input  logic [NW-1:0] next_val,
    output logic          pulse
);
    localparam logic [NW-1:0] ONE = NW'(1);
    localparam logic [NW-1:0] TWO = NW'(2);
    localparam logic [NW-1:0] RELOAD_FLOOR = NW'(MIN_INT - 1);

    div_state_t    state;
    logic [NW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_START;
            cnt   <= '0;
        end else if (tick) begin
            unique case (state)
                ST_START: begin
                    cnt   <= first_val - TWO;
                    state <= ST_RUN;
                end
                ST_RUN: begin
                    if (cnt == '0) begin
                        cnt <= next_val - ONE;
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                default: state <= ST_START;
            endcase
        end
    end

    always_comb begin
        pulse = (state == ST_RUN) && tick && (cnt == '0);
    end

    // R8: a pulse never lasts into the next cycle
    p_pulse_narrow_r8: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    // R1: every reload leaves at least MIN_INT-1 steps before the next pulse
    p_reload_floor_r1: assert property (@(posedge clk) disable iff (rst)
        pulse |=> (cnt >= RELOAD_FLOOR));

    // R5: inside a period the count only steps down by one; nothing reloads it early
    p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && tick && cnt != '0) |=> (cnt == $past(cnt) - ONE));

endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top #(
    parameter int NW        = 19,
    parameter int OW        = 4,
    parameter int TSW       = 5,
    parameter int MIN_INT   = 16,
    parameter int MARGIN    = 4,
    parameter int TSEL_CODE = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NW-1:0]  div_val,
    input  logic           frac_en,
    input  logic [OW-1:0]  dsm_off,
    input  logic           presc_en,
    input  logic [TSW-1:0] tsel,
    output logic           div_pulse,
    output logic           test_out,
    output logic           range_err
);
    logic [NW-1:0] base_legal;
    logic [NW-1:0] period_val;
    logic          tick;

    fbdiv_limits #(
        .NW      (NW),
        .OW      (OW),
        .MIN_INT (MIN_INT),
        .MARGIN  (MARGIN)
    ) u_limits (
        .base       (div_val),
        .frac_en    (frac_en),
        .offset     (dsm_off),
        .base_legal (base_legal),
        .period_val (period_val),
        .err        (range_err)
    );

    fbdiv_presc u_presc (
        .clk      (clk),
        .rst      (rst),
        .presc_en (presc_en),
        .tick     (tick)
    );

    fbdiv_count #(
        .NW      (NW),
        .MIN_INT (MIN_INT)
    ) u_count (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .first_val (base_legal),
        .next_val  (period_val),
        .pulse     (div_pulse)
    );

    always_comb begin
        test_out = (tsel == TSW'(TSEL_CODE)) ? div_pulse : 1'b0;
    end

    // R10: the reset holds the divided output quiet
    p_reset_quiet_r10: assert property (@(posedge clk)
        rst |=> !div_pulse);

endmodule

// File: tb/fbdiv_top_bench.sv
module fbdiv_top_bench;
    localparam int NW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NW-1:0] div_val = '0;
    logic          frac_en = 1'b0;
    logic [3:0]    dsm_off = '0;
    logic          presc_en = 1'b0;
    logic [4:0]    tsel = '0;
    logic          div_pulse;
    logic          test_out;
    logic          range_err;

    int compared = 0;
    int mismatched = 0;

    always #4 clk = ~clk;

    fbdiv_top #(.NW(NW)) u_fbdiv_top (
        .clk       (clk),
        .rst       (rst),
        .div_val   (div_val),
        .frac_en   (frac_en),
        .dsm_off   (dsm_off),
        .presc_en  (presc_en),
        .tsel      (tsel),
        .div_pulse (div_pulse),
        .test_out  (test_out),
        .range_err (range_err)
    );

    localparam int NV = 12;
    localparam int V_FRAC [NV] = '{0, 0, 0, 1, 1, 1, 1, 1, 1, 0, 1, 0};
    localparam int V_PRE  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0};
    localparam int V_BASE [NV] = '{16, 5, 63, 30, 30, 30, 30, 17, 62, 16, 20, 0};
    localparam int V_OFF  [NV] = '{3, 0, 0, 3, 13, 7, 8, 0, 14, 0, 12, 5};
    localparam int V_FIRST[NV] = '{15, 15, 62, 29, 29, 29, 29, 19, 58, 30, 38, 15};
    localparam int V_INTV [NV] = '{16, 16, 63, 33, 27, 34, 26, 20, 57, 32, 32, 16};
    localparam int V_ERR  [NV] = '{0, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0, 1};
    localparam string V_TAG[NV] = '{"R3", "R1", "R1", "R3", "R3", "R4", "R4",
                                    "R2", "R2", "R7", "R7", "R1"};

    task automatic check(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_pulse(output int c);
        c = 0;
        do begin
            @(negedge clk);
            c++;
        end while (!div_pulse && c < 2000);
    endtask

    initial begin
        int c;
        int c2;

        // R10: quiet outputs while reset is held
        tsel = 5'd10;
        div_val = 6'd16;
        @(negedge clk);
        @(negedge clk);
        check("R10 pulse in reset", int'(div_pulse), 0);
        check("R10 test_out in reset", int'(test_out), 0);
        tsel = 5'd0;

        for (int i = 0; i < NV; i++) begin
            frac_en  = V_FRAC[i][0];
            presc_en = V_PRE[i][0];
            div_val  = V_BASE[i][NW-1:0];
            dsm_off  = V_OFF[i][3:0];
            do_reset();
            check({V_TAG[i], " range_err"}, int'(range_err), V_ERR[i]);
            wait_pulse(c);
            check({"R6 first period ", V_TAG[i]}, c, V_FIRST[i]);
            @(negedge clk);
            check("R8 pulse width", int'(div_pulse), 0);
            wait_pulse(c2);
            check({V_TAG[i], " interval"}, c2 + 1, V_INTV[i]);
        end

        // R5: offset changed mid-period is held until the boundary
        frac_en = 1'b1;
        presc_en = 1'b0;
        div_val = 6'd30;
        dsm_off = 4'd2;
        do_reset();
        wait_pulse(c);
        check("R6 first period R5 case", c, 29);
        repeat (5) @(negedge clk);
        dsm_off = 4'hE;
        wait_pulse(c2);
        check("R5 period kept", c2 + 5, 32);
        wait_pulse(c2);
        check("R5 new offset next period", c2, 28);

        // R9: test output select
        frac_en = 1'b0;
        dsm_off = 4'd0;
        div_val = 6'd16;
        tsel = 5'd10;
        do_reset();
        wait_pulse(c);
        check("R9 test_out selected", int'(test_out), 1);
        tsel = 5'd9;
        wait_pulse(c);
        check("R9 pulse present", int'(div_pulse), 1);
        check("R9 test_out deselected", int'(test_out), 0);

        // R10: reset mid-period restarts the first period without offset
        frac_en = 1'b1;
        div_val = 6'd25;
        dsm_off = 4'd3;
        do_reset();
        wait_pulse(c);
        repeat (7) @(negedge clk);
        do_reset();
        wait_pulse(c);
        check("R10 restart first period", c, 24);
        wait_pulse(c2);
        check("R10 restart interval", c2, 28);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule